// File: doc/BRIEF.md
# Masked-Write Control Register Bank

This block holds a small set of 16-bit control words that hardware reads continuously. Each write to the bank updates only the bits it selects. A 32-bit write word carries a per-bit enable mask in its upper half and new bit values in its lower half. A bit whose enable is clear keeps its old value. Software can therefore set or clear one field of a shared control word in a single write, with no read-modify-write, and cannot disturb a field that another agent owns in the same word.

The bank has one write port (valid, word address, data) and one read port (word address in, registered data out). Control words sit at word addresses 0 to `N_CTRL-1`. A read-only status word at address `STAT_IDX` returns an external status bus. Two of the control words are also split into named field outputs:
- a per-lane word holds four groups of lane controls;
- a test-port word drives an 8-bit data byte and three strobes.

Top module: `wmask_bank`

## Requirements
- R1: After a synchronous reset every control bit is 0 and `rd_data` is 0.
- R2: A write to control word A sets each bit i (0..15) of word A to `wr_data[i]` when `wr_data[16+i]` is 1, and leaves it unchanged when `wr_data[16+i]` is 0. The new value is visible on `ctrl_flat` after the clock edge that samples `wr_valid`.
- R3: A write whose mask half is all zero leaves the addressed word unchanged.
- R4: Bits [31:16] of `rd_data` are always 0. A read of control word A returns that word in bits [15:0].
- R5: A read of address `STAT_IDX` (default 8) returns `status_in` in bits [`STAT_W`-1:0] and zero above. `status_in` is sampled at the read edge. Writes to `STAT_IDX` change no control bit.
- R6: Addresses from `N_CTRL` (default 6) up to the top of the space, other than `STAT_IDX`, read as 0. A write to any address at or above `N_CTRL` changes no control bit.
- R7: Control word `LANE_IDX` (default 1) drives four lane fields of `LANES` (default 4) bits each: `lane_en` in bits [3:0], `rx_force` in [7:4], `stop_force` in [11:8] and `turn_off` in [15:12].
- R8: Control word `TP_IDX` (default 5) drives the test port: `tp_din` in bits [7:0], `tp_en` in bit 8, `tp_clk` in bit 9 and `tp_clr` in bit 10.
- R9: `rd_data` appears one clock after the read address is presented. A read in the same cycle as a write to the same word returns the value from before the write.
- R10: A write changes only the addressed word. All other control words keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write strobe, sampled on the rising edge |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 32 | [31:16] bit enables, [15:0] new values |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | 32 | Registered read data |
| status_in | input | STAT_W | External status bus, read through `STAT_IDX` |
| ctrl_flat | output | N_CTRL*16 | All control words; word k is in bits [16k+15:16k] |
| lane_en | output | LANES | Lane enable field |
| rx_force | output | LANES | Force-receive field |
| stop_force | output | LANES | Force-stop field |
| turn_off | output | LANES | Turnaround-disable field |
| tp_din | output | 8 | Test-port data byte |
| tp_en | output | 1 | Test-port enable strobe |
| tp_clk | output | 1 | Test-port clock level |
| tp_clr | output | 1 | Test-port clear level |

## Verification
The merge is first tried with a full mask, which shows that values land in the word. A nibble-wide mask and then a byte-wide mask follow. These separate a correct per-bit merge from a design that writes the whole word or ignores the mask. An all-zero mask with all-ones data catches a merge that treats data bits as enables.

Field-by-field writes to the lane and test-port words check that each field stays put while its neighbours change. Writes aimed at the status address and at unmapped addresses each carry all-ones data, so any leak into a control word shows up. A write and a read of the same word in one cycle confirms that the read returns the value from before the write.

// File: rtl/wmask_pkg.sv
package wmask_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;

  typedef logic [HALF_W-1:0] half_t;

  // Upper half: per-bit enables; lower half: new bit values.
  typedef struct packed {
    half_t mask;
    half_t val;
  } wr_word_t;
endpackage

// File: rtl/wmask_merge.sv
module wmask_merge
  import wmask_pkg::*;
(
  input  half_t    cur,
  input  wr_word_t wr,
  output half_t    nxt
);
  always_comb nxt = (cur & ~wr.mask) | (wr.val & wr.mask);
endmodule

// File: rtl/wmask_word.sv
module wmask_word
  import wmask_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     we,
  input  wr_word_t wr,
  output half_t    q
);
  half_t nxt;

  wmask_merge u_merge (
    .cur (q),
    .wr  (wr),
    .nxt (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= nxt;
  end
endmodule

// File: rtl/wmask_rdmux.sv
module wmask_rdmux
  import wmask_pkg::*;
#(
  parameter int N_CTRL   = 6,
  parameter int ADDR_W   = 4,
  parameter int STAT_IDX = 8,
  parameter int STAT_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic [N_CTRL*HALF_W-1:0] ctrl_flat,
  input  logic [STAT_W-1:0]        status_in,
  output logic [WORD_W-1:0]        rd_data
);
  logic [WORD_W-1:0] rd_nxt;

  always_comb begin
    rd_nxt = '0;
    if (rd_addr == ADDR_W'(STAT_IDX)) begin
      rd_nxt[STAT_W-1:0] = status_in;
    end else begin
      for (int i = 0; i < N_CTRL; i++) begin
        if (rd_addr == ADDR_W'(i)) rd_nxt[HALF_W-1:0] = ctrl_flat[i*HALF_W +: HALF_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_nxt;
  end
endmodule

// File: rtl/wmask_bank.sv
module wmask_bank
  import wmask_pkg::*;
#(
  parameter int N_CTRL   = 6,
  parameter int ADDR_W   = 4,
  parameter int STAT_IDX = 8,
  parameter int STAT_W   = 8,
  parameter int LANE_IDX = 1,
  parameter int TP_IDX   = 5,
  parameter int LANES    = 4,
  localparam int FLAT_W  = N_CTRL * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic [STAT_W-1:0] status_in,
  output logic [FLAT_W-1:0] ctrl_flat,
  output logic [LANES-1:0]  lane_en,
  output logic [LANES-1:0]  rx_force,
  output logic [LANES-1:0]  stop_force,
  output logic [LANES-1:0]  turn_off,
  output logic [7:0]        tp_din,
  output logic              tp_en,
  output logic              tp_clk,
  output logic              tp_clr
);
  wr_word_t wr_s;
  half_t    lane_w;
  half_t    tp_w;

  assign wr_s = wr_data;

  for (genvar g = 0; g < N_CTRL; g++) begin : g_word
    logic hit;
    assign hit = wr_valid && (wr_addr == ADDR_W'(g));
    wmask_word u_word (
      .clk (clk),
      .rst (rst),
      .we  (hit),
      .wr  (wr_s),
      .q   (ctrl_flat[g*HALF_W +: HALF_W])
    );
  end

  wmask_rdmux #(
    .N_CTRL   (N_CTRL),
    .ADDR_W   (ADDR_W),
    .STAT_IDX (STAT_IDX),
    .STAT_W   (STAT_W)
  ) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_addr   (rd_addr),
    .ctrl_flat (ctrl_flat),
    .status_in (status_in),
    .rd_data   (rd_data)
  );

  // Field views of the lane word and the test-port word.
  assign lane_w     = ctrl_flat[LANE_IDX*HALF_W +: HALF_W];
  assign lane_en    = lane_w[0*LANES +: LANES];
  assign rx_force   = lane_w[1*LANES +: LANES];
  assign stop_force = lane_w[2*LANES +: LANES];
  assign turn_off   = lane_w[3*LANES +: LANES];

  assign tp_w   = ctrl_flat[TP_IDX*HALF_W +: HALF_W];
  assign tp_din = tp_w[7:0];
  assign tp_en  = tp_w[8];
  assign tp_clk = tp_w[9];
  assign tp_clr = tp_w[10];
endmodule

// File: rtl/wmask_bank_chk.sv
module wmask_bank_chk #(
  parameter int N_CTRL   = 6,
  parameter int ADDR_W   = 4,
  parameter int STAT_IDX = 8,
  parameter int STAT_W   = 8,
  parameter int LANE_IDX = 1,
  parameter int LANES    = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_valid,
  input logic [ADDR_W-1:0]      wr_addr,
  input logic [31:0]            wr_data,
  input logic [ADDR_W-1:0]      rd_addr,
  input logic [31:0]            rd_data,
  input logic [STAT_W-1:0]      status_in,
  input logic [N_CTRL*16-1:0]   ctrl_flat,
  input logic [LANES-1:0]       lane_en,
  input logic [LANES-1:0]       rx_force,
  input logic [LANES-1:0]       stop_force,
  input logic [LANES-1:0]       turn_off
);
  logic [4*LANES-1:0] lane_w;
  assign lane_w = {turn_off, stop_force, rx_force, lane_en};

  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (ctrl_flat == '0 && rd_data == '0));

  // R2: disabled bits hold
  p_masked_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_addr == ADDR_W'(LANE_IDX)) |=>
      (((lane_w ^ $past(lane_w)) & ~$past(wr_data[31:16])) == '0));

  // R2: enabled bits take the new value
  p_masked_take_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_addr == ADDR_W'(LANE_IDX)) |=>
      ((lane_w & $past(wr_data[31:16])) == ($past(wr_data[15:0]) & $past(wr_data[31:16]))));

  // R3, R10: no write, no change
  p_idle_stable_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |=> $stable(ctrl_flat));

  // R4
  p_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
    rd_data[31:16] == 16'h0);

  // R5
  p_status_read_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == ADDR_W'(STAT_IDX)) |=>
      (rd_data == {{(32-STAT_W){1'b0}}, $past(status_in)}));

  // R6
  p_unmapped_write_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_addr >= ADDR_W'(N_CTRL)) |=> $stable(ctrl_flat));
endmodule

bind wmask_bank wmask_bank_chk #(
  .N_CTRL   (N_CTRL),
  .ADDR_W   (ADDR_W),
  .STAT_IDX (STAT_IDX),
  .STAT_W   (STAT_W),
  .LANE_IDX (LANE_IDX),
  .LANES    (LANES)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_valid   (wr_valid),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .rd_addr    (rd_addr),
  .rd_data    (rd_data),
  .status_in  (status_in),
  .ctrl_flat  (ctrl_flat),
  .lane_en    (lane_en),
  .rx_force   (rx_force),
  .stop_force (stop_force),
  .turn_off   (turn_off)
);

// File: tb/tb_wmask_bank.sv
module tb_wmask_bank;
  localparam int CLK_P  = 10;
  localparam int N_CTRL = 6;
  localparam int ADDR_W = 4;
  localparam int STAT   = 8;
  localparam int FLAT_W = N_CTRL * 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_valid = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [31:0]       wr_data = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [31:0]       rd_data;
  logic [7:0]        status_in = 8'h00;
  logic [FLAT_W-1:0] ctrl_flat;
  logic [3:0]        lane_en, rx_force, stop_force, turn_off;
  logic [7:0]        tp_din;
  logic              tp_en, tp_clk, tp_clr;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [15:0] model [N_CTRL];

  wmask_bank dut (
    .clk (clk), .rst (rst), .wr_valid (wr_valid), .wr_addr (wr_addr),
    .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data),
    .status_in (status_in), .ctrl_flat (ctrl_flat),
    .lane_en (lane_en), .rx_force (rx_force), .stop_force (stop_force),
    .turn_off (turn_off), .tp_din (tp_din), .tp_en (tp_en),
    .tp_clk (tp_clk), .tp_clr (tp_clr)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input logic [FLAT_W-1:0] act, input logic [FLAT_W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [FLAT_W-1:0] model_flat();
    logic [FLAT_W-1:0] f;
    for (int i = 0; i < N_CTRL; i++) f[i*16 +: 16] = model[i];
    return f;
  endfunction

  task automatic do_write(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    if (a < N_CTRL) model[a] = (model[a] & ~d[31:16]) | (d[15:0] & d[31:16]);
  endtask

  task automatic do_read(input int a, output logic [31:0] v);
    @(negedge clk);
    rd_addr = ADDR_W'(a);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 ctrl_flat after reset", ctrl_flat, '0);
    check("R1 rd_data after reset", FLAT_W'(rd_data), '0);
    for (int i = 0; i < N_CTRL; i++) begin
      do_read(i, v);
      check("R1 word read after reset", FLAT_W'(v), '0);
    end
  endtask

  task automatic t_merge();
    logic [31:0] v;
    do_write(2, 32'hFFFF_A5A5);
    check("R2 full-mask write", ctrl_flat, model_flat());
    do_write(2, 32'h00F0_0F0F);
    check("R2 nibble-mask write", FLAT_W'(ctrl_flat[2*16 +: 16]), FLAT_W'(16'hA505));
    do_write(2, 32'hFF00_1234);
    check("R2 byte-mask write", FLAT_W'(ctrl_flat[2*16 +: 16]), FLAT_W'(16'h1205));
    do_read(2, v);
    check("R4 read word with upper zero", FLAT_W'(v), FLAT_W'(32'h0000_1205));
    check("R10 other words untouched", ctrl_flat, model_flat());
  endtask

  task automatic t_zero_mask();
    do_write(2, 32'h0000_FFFF);
    check("R3 zero mask no change", FLAT_W'(ctrl_flat[2*16 +: 16]), FLAT_W'(16'h1205));
  endtask

  task automatic t_status();
    logic [31:0] v;
    status_in = 8'h5A;
    do_read(STAT, v);
    check("R5 status read 5A", FLAT_W'(v), FLAT_W'(32'h0000_005A));
    status_in = 8'hC3;
    do_read(STAT, v);
    check("R5 status read C3", FLAT_W'(v), FLAT_W'(32'h0000_00C3));
    do_write(STAT, 32'hFFFF_FFFF);
    check("R5 status write ignored", ctrl_flat, model_flat());
    do_read(STAT, v);
    check("R5 status after write", FLAT_W'(v), FLAT_W'(32'h0000_00C3));
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    do_write(6, 32'hFFFF_FFFF);
    do_write(7, 32'hFFFF_FFFF);
    do_write(15, 32'hFFFF_FFFF);
    check("R6 unmapped writes ignored", ctrl_flat, model_flat());
    do_read(6, v);
    check("R6 unmapped read 6", FLAT_W'(v), '0);
    do_read(15, v);
    check("R6 unmapped read 15", FLAT_W'(v), '0);
  endtask

  task automatic t_lanes();
    do_write(1, 32'h000F_0003);
    check("R7 lane_en set", FLAT_W'({turn_off, stop_force, rx_force, lane_en}), FLAT_W'(16'h0003));
    do_write(1, 32'h00F0_00A0);
    check("R7 rx_force set, lane_en kept", FLAT_W'({turn_off, stop_force, rx_force, lane_en}), FLAT_W'(16'h00A3));
    do_write(1, 32'hF000_F000);
    check("R7 turn_off set", FLAT_W'(turn_off), FLAT_W'(4'hF));
    do_write(1, 32'h0F00_0600);
    check("R7 stop_force set", FLAT_W'({turn_off, stop_force, rx_force, lane_en}), FLAT_W'(16'hF6A3));
    check("R10 lane writes stay in word", ctrl_flat, model_flat());
  endtask

  task automatic t_test_port();
    do_write(5, 32'h0200_0200);
    check("R8 tp_clk high", FLAT_W'({tp_clr, tp_clk, tp_en, tp_din}), FLAT_W'(11'h200));
    do_write(5, 32'h00FF_0044);
    check("R8 tp_din loaded", FLAT_W'({tp_clr, tp_clk, tp_en, tp_din}), FLAT_W'(11'h244));
    do_write(5, 32'h0100_0100);
    check("R8 tp_en high", FLAT_W'(tp_en), FLAT_W'(1'b1));
    do_write(5, 32'h0200_0000);
    check("R8 tp_clk low, rest kept", FLAT_W'({tp_clr, tp_clk, tp_en, tp_din}), FLAT_W'(11'h144));
    do_write(5, 32'h0400_0400);
    check("R8 tp_clr high", FLAT_W'(tp_clr), FLAT_W'(1'b1));
  endtask

  task automatic t_read_during_write();
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 4'd3; wr_data = 32'hFFFF_BEEF; rd_addr = 4'd3;
    @(negedge clk);
    wr_valid = 1'b0;
    model[3] = 16'hBEEF;
    check("R9 same-cycle read returns old", FLAT_W'(rd_data), '0);
    @(negedge clk);
    check("R9 next read returns new", FLAT_W'(rd_data), FLAT_W'(32'h0000_BEEF));
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1..all actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N_CTRL; i++) model[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_merge();
    t_zero_mask();
    t_status();
    t_unmapped();
    t_lanes();
    t_test_port();
    t_read_during_write();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule